// File: doc/BRIEF.md
# Floating-Point Operand Unpack Classifier

This block takes one packed operand per cycle and turns it into a fixed internal form that downstream floating-point arithmetic can use. The operand is either a 32-bit two's-complement integer or an IEEE-style binary float in single, double or quad width. The float is held in one, two or four 32-bit words, with the first word carrying the sign and exponent. The internal form has a sign, a signed unbiased exponent, and a 115-bit mantissa whose leading one, when present, sits in the top bit. It also carries a class code and an invalid-operation flag.

All four formats go through one decode path. Denormals and nonzero integers are renormalized with a leading-zero count and a left barrel shift. A NaN whose top fraction bit is clear is quieted on the way in: it is reported with its own class and raises the invalid flag. The result is registered, so each accepted operand appears exactly one clock later.

Top module: `fp_unpack`

## Requirements
- R1: `out_sign` equals bit 31 of `in_w0` for every format code, including integers and illegal codes.
- R2: A float with biased exponent 0 and a zero fraction gives class ZERO (code 0), with `out_exp` 0 and `out_mant` 0.
- R3: A float with biased exponent 0 and a nonzero fraction gives class NUMBER (code 1). The fraction is normalized so that its leading one lands at mantissa bit 114. For a fraction of width F whose highest set bit is p, `out_exp` is 1 - bias - F + p.
- R4: A normal float gives class NUMBER. `out_exp` is the biased exponent minus the bias, and `out_mant` is a one at bit 114 with the fraction left-aligned directly below it. The rest of the mantissa is zero.
- R5: A float with an all-ones exponent and a zero fraction gives class INFINITY (code 2), with `out_mant` 0 and `out_exp` equal to bias + 1.
- R6: An all-ones exponent with the top fraction bit set gives class QNAN (code 3). `out_mant` holds the fraction left-aligned below a zero bit 114, `out_exp` is bias + 1, and `out_invalid` is 0.
- R7: An all-ones exponent with a nonzero fraction whose top bit is clear gives class SNAN (code 4). `out_mant` is built as in R6 but with bit 113 forced to 1, and `out_invalid` is 1. `out_invalid` is never 1 for any other class.
- R8: In integer format the value 0 gives class ZERO. Any other value gives class NUMBER from its magnitude (2^31 for 0x80000000), normalized to bit 114, with `out_exp` equal to the index of the magnitude's highest set bit.
- R9: Format codes are: 0 integer, 1 single (8-bit exponent, bias 127, 23-bit fraction), 2 double (11, 1023, 52), 3 quad (15, 16383, 112). Codes 4 to 7 give class ZERO, `out_exp` 0, `out_mant` 0, `out_invalid` 0 and `out_fmt_err` 1. `out_fmt_err` is 0 for legal codes.
- R10: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, and low otherwise. Back-to-back operands are accepted every cycle. While `in_valid` is low, all result outputs hold their values.
- R11: While `rst_n` is low at a clock edge, `out_valid` and all result outputs are cleared to 0.
- R12: Words the selected format does not use have no effect: `in_w1`..`in_w3` for integer and single, and `in_w2`, `in_w3` for double. A float's exponent is taken from bits 30 down of `in_w0` and its fraction follows immediately below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_fmt | input | 3 | Format code (0 int, 1 single, 2 double, 3 quad) |
| in_w0 | input | 32 | Most significant operand word (sign, exponent) |
| in_w1 | input | 32 | Second operand word |
| in_w2 | input | 32 | Third operand word |
| in_w3 | input | 32 | Least significant operand word |
| out_valid | output | 1 | Result present |
| out_sign | output | 1 | Sign |
| out_exp | output | 16 | Unbiased exponent, two's complement |
| out_mant | output | 115 | Mantissa, leading one at bit 114 for numbers |
| out_class | output | 3 | 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| out_invalid | output | 1 | Invalid-operation flag (signalling NaN input) |
| out_fmt_err | output | 1 | Illegal format code |

## Verification
A wrong leading-zero count or a bad shifter stage shows up at the ports one cycle after the operand is accepted. It appears as a NUMBER whose mantissa top bit is clear, or whose exponent is off by the same amount the mantissa is misplaced. A fault in exponent or fraction extraction for one format shows only for operands of that format. That is why every format is swept: all single exponents against several fraction patterns, powers of two and random integers, and pseudo-random double and quad words. The tests also cover the edge values: zeros, the extreme denormals and normals, infinities and both NaN kinds. A stuck capture register shows as stale data on the next accepted operand, or as data that changes while the input strobe is low.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_NUM  = 3'd1,
      CLS_INF  = 3'd2,
      CLS_QNAN = 3'd3,
      CLS_SNAN = 3'd4
   } fp_class_e;

   typedef enum logic [2:0] {
      FMT_INT  = 3'd0,
      FMT_SGL  = 3'd1,
      FMT_DBL  = 3'd2,
      FMT_QUAD = 3'd3
   } fp_fmt_e;

   // number of float widths handled; index 0 single, 1 double, 2 quad
   localparam int N_FLT   = 3;
   localparam int INT_W   = 32;
   localparam int OP_W    = 128;

   function automatic int flt_exp_w(input int idx);
      case (idx)
         0:       return 8;
         1:       return 11;
         default: return 15;
      endcase
   endfunction

   function automatic int flt_frac_w(input int idx);
      case (idx)
         0:       return 23;
         1:       return 52;
         default: return 112;
      endcase
   endfunction

endpackage

// File: rtl/fpu_unpack_decode.sv
module fpu_unpack_decode
   import fpu_unpack_pkg::*;
#(
   parameter int MANT_W = 115,
   parameter int EXP_W  = 16
) (
   input  logic [2:0]              fmt,
   input  logic [OP_W-1:0]         op,
   output logic                    sign,
   output logic [MANT_W-1:0]       pre_mant,
   output logic signed [EXP_W-1:0] pre_exp,
   output logic                    norm_req,
   output fp_class_e               cls,
   output logic                    invalid,
   output logic                    fmt_err
);

   localparam int TOP = OP_W - 2;   // first bit below the sign

   assign sign = op[OP_W-1];

   // one decode slice per float width
   for (genvar g = 0; g < N_FLT; g++) begin : g_flt
      localparam int EW   = flt_exp_w(g);
      localparam int FW   = flt_frac_w(g);
      localparam int BIAS = (1 << (EW - 1)) - 1;

      logic [EW-1:0]            e_fld;
      logic [FW-1:0]            f_fld;
      logic [MANT_W-1:0]        mant;
      logic signed [EXP_W-1:0]  expo;
      logic                     norm;
      fp_class_e                c;
      logic                     inv;

      assign e_fld = op[TOP -: EW];
      assign f_fld = op[TOP-EW -: FW];

      always_comb begin
         mant = '0;
         expo = '0;
         norm = 1'b0;
         c    = CLS_ZERO;
         inv  = 1'b0;
         if (e_fld == '0) begin
            if (f_fld != '0) begin
               mant[MANT_W-2 -: FW] = f_fld;
               expo = EXP_W'(1 - BIAS);
               norm = 1'b1;
               c    = CLS_NUM;
            end
         end else if (&e_fld) begin
            expo = EXP_W'(BIAS + 1);
            if (f_fld == '0) begin
               c = CLS_INF;
            end else begin
               mant[MANT_W-2 -: FW] = f_fld;
               if (f_fld[FW-1]) begin
                  c = CLS_QNAN;
               end else begin
                  mant[MANT_W-2] = 1'b1;
                  c   = CLS_SNAN;
                  inv = 1'b1;
               end
            end
         end else begin
            mant[MANT_W-1]       = 1'b1;
            mant[MANT_W-2 -: FW] = f_fld;
            expo = EXP_W'(int'(e_fld) - BIAS);
            c    = CLS_NUM;
         end
      end
   end

   // integer slice: two's complement to sign-magnitude
   logic [INT_W-1:0] int_word;
   logic [INT_W-1:0] int_mag;
   assign int_word = op[OP_W-1 -: INT_W];
   assign int_mag  = int_word[INT_W-1] ? (~int_word + 32'd1) : int_word;

   always_comb begin
      pre_mant = '0;
      pre_exp  = '0;
      norm_req = 1'b0;
      cls      = CLS_ZERO;
      invalid  = 1'b0;
      fmt_err  = 1'b0;
      case (fmt)
         FMT_INT: begin
            if (int_mag != '0) begin
               pre_mant[MANT_W-1 -: INT_W] = int_mag;
               pre_exp  = EXP_W'(INT_W - 1);
               norm_req = 1'b1;
               cls      = CLS_NUM;
            end
         end
         FMT_SGL: begin
            pre_mant = g_flt[0].mant;
            pre_exp  = g_flt[0].expo;
            norm_req = g_flt[0].norm;
            cls      = g_flt[0].c;
            invalid  = g_flt[0].inv;
         end
         FMT_DBL: begin
            pre_mant = g_flt[1].mant;
            pre_exp  = g_flt[1].expo;
            norm_req = g_flt[1].norm;
            cls      = g_flt[1].c;
            invalid  = g_flt[1].inv;
         end
         FMT_QUAD: begin
            pre_mant = g_flt[2].mant;
            pre_exp  = g_flt[2].expo;
            norm_req = g_flt[2].norm;
            cls      = g_flt[2].c;
            invalid  = g_flt[2].inv;
         end
         default: fmt_err = 1'b1;
      endcase
   end

endmodule

// File: rtl/fpu_unpack_lzc.sv
module fpu_unpack_lzc #(
   parameter int W  = 115,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);

   if (W < 2) begin : g_bad_w
      $error("fpu_unpack_lzc: W must be at least 2");
   end

   // highest set bit wins because it is visited last
   always_comb begin
      cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec[i]) cnt = CW'(W - 1 - i);
      end
   end

endmodule

// File: rtl/fpu_unpack_shl.sv
module fpu_unpack_shl #(
   parameter int W  = 115,
   parameter int SW = 7
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);

   if ((1 << SW) < W) begin : g_bad_sw
      $error("fpu_unpack_shl: SW too narrow for W");
   end

   logic [SW:0][W-1:0] stg;

   assign stg[0] = din;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
   end

   assign dout = stg[SW];

endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
   import fpu_unpack_pkg::*;
#(
   parameter int MANT_W = 115,
   parameter int EXP_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [2:0]              in_fmt,
   input  logic [31:0]             in_w0,
   input  logic [31:0]             in_w1,
   input  logic [31:0]             in_w2,
   input  logic [31:0]             in_w3,
   output logic                    out_valid,
   output logic                    out_sign,
   output logic signed [EXP_W-1:0] out_exp,
   output logic [MANT_W-1:0]       out_mant,
   output logic [2:0]              out_class,
   output logic                    out_invalid,
   output logic                    out_fmt_err
);

   localparam int CNT_W = $clog2(MANT_W + 1);

   if (MANT_W < flt_frac_w(N_FLT - 1) + 1 || MANT_W < INT_W) begin : g_bad_mant
      $error("fp_unpack: MANT_W cannot hold the widest fraction");
   end
   if (EXP_W < 16) begin : g_bad_exp
      $error("fp_unpack: EXP_W too narrow for quad denormals");
   end

   logic                    d_sign;
   logic [MANT_W-1:0]       d_mant;
   logic signed [EXP_W-1:0] d_exp;
   logic                    d_norm;
   fp_class_e               d_cls;
   logic                    d_inv;
   logic                    d_err;
   logic [CNT_W-1:0]        lz;
   logic [MANT_W-1:0]       sh_mant;
   logic [MANT_W-1:0]       n_mant;
   logic signed [EXP_W-1:0] n_exp;

   fpu_unpack_decode #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_dec (
      .fmt      (in_fmt),
      .op       ({in_w0, in_w1, in_w2, in_w3}),
      .sign     (d_sign),
      .pre_mant (d_mant),
      .pre_exp  (d_exp),
      .norm_req (d_norm),
      .cls      (d_cls),
      .invalid  (d_inv),
      .fmt_err  (d_err)
   );

   fpu_unpack_lzc #(.W(MANT_W), .CW(CNT_W)) u_lzc (
      .vec (d_mant),
      .cnt (lz)
   );

   fpu_unpack_shl #(.W(MANT_W), .SW(CNT_W)) u_shl (
      .din  (d_mant),
      .amt  (lz),
      .dout (sh_mant)
   );

   assign n_mant = d_norm ? sh_mant : d_mant;
   assign n_exp  = d_norm ? (d_exp - EXP_W'(lz)) : d_exp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_sign    <= 1'b0;
         out_exp     <= '0;
         out_mant    <= '0;
         out_class   <= CLS_ZERO;
         out_invalid <= 1'b0;
         out_fmt_err <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sign    <= d_sign;
            out_exp     <= n_exp;
            out_mant    <= n_mant;
            out_class   <= d_cls;
            out_invalid <= d_inv;
            out_fmt_err <= d_err;
         end
      end
   end

   // R10
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_mant) && $stable(out_exp) && $stable(out_class)));
   // R3
   num_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_class == CLS_NUM) |-> out_mant[MANT_W-1]);
   // R7
   inv_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_invalid == (out_class == CLS_SNAN)));
   // R6
   nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_class == CLS_QNAN || out_class == CLS_SNAN))
         |-> (out_mant[MANT_W-2] && !out_mant[MANT_W-1]));
   // R9
   fmt_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fmt_err) |-> (out_class == CLS_ZERO && !out_invalid));

endmodule

// File: tb/fp_unpack_test.sv
`timescale 1ns/1ps
module fp_unpack_test;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic [2:0]         in_fmt = '0;
   logic [31:0]        in_w0 = '0, in_w1 = '0, in_w2 = '0, in_w3 = '0;
   logic               out_valid;
   logic               out_sign;
   logic signed [15:0] out_exp;
   logic [114:0]       out_mant;
   logic [2:0]         out_class;
   logic               out_invalid;
   logic               out_fmt_err;

   int checks = 0;
   int errors = 0;
   logic [31:0] lfsr = 32'hACE1_2468;

   always #4 clk = ~clk;

   fp_unpack uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
      .in_w0(in_w0), .in_w1(in_w1), .in_w2(in_w2), .in_w3(in_w3),
      .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
      .out_mant(out_mant), .out_class(out_class), .out_invalid(out_invalid),
      .out_fmt_err(out_fmt_err)
   );

   function automatic logic [31:0] rnd();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr;
   endfunction

   // expected result computed from the requirements
   task automatic model(input logic [2:0] f, input logic [127:0] op,
                        output logic sg, output logic signed [15:0] ex,
                        output logic [114:0] mt, output logic [2:0] cl,
                        output logic iv, output logic er);
      int ew, fw, bias, e, p;
      logic [111:0] fr;
      logic [31:0]  mag;
      logic [127:0] wide;
      sg = op[127]; ex = '0; mt = '0; cl = 3'd0; iv = 1'b0; er = 1'b0;
      if (f == 3'd0) begin
         mag = op[127] ? (32'd0 - op[127:96]) : op[127:96];
         if (mag != 0) begin
            p = 0;
            for (int i = 0; i < 32; i++) if (mag[i]) p = i;
            wide = 128'(mag) << (114 - p);
            mt = wide[114:0]; ex = 16'(p); cl = 3'd1;
         end
      end else if (f <= 3'd3) begin
         case (f)
            3'd1:    begin ew = 8;  fw = 23;  end
            3'd2:    begin ew = 11; fw = 52;  end
            default: begin ew = 15; fw = 112; end
         endcase
         bias = (1 << (ew - 1)) - 1;
         e  = int'((op >> (127 - ew)) & ((128'd1 << ew) - 1));
         fr = 112'((op >> (127 - ew - fw)) & ((128'd1 << fw) - 1));
         if (e == 0) begin
            if (fr != 0) begin
               p = 0;
               for (int i = 0; i < fw; i++) if (fr[i]) p = i;
               wide = 128'(fr) << (114 - p);
               mt = wide[114:0]; ex = 16'(1 - bias - fw + p); cl = 3'd1;
            end
         end else if (e == 2 * bias + 1) begin
            ex = 16'(bias + 1);
            if (fr == 0) cl = 3'd2;
            else begin
               wide = 128'(fr) << (114 - fw);
               mt = wide[114:0];
               if (fr[fw-1]) cl = 3'd3;
               else begin mt[113] = 1'b1; cl = 3'd4; iv = 1'b1; end
            end
         end else begin
            wide = (128'(fr) | (128'd1 << fw)) << (114 - fw);
            mt = wide[114:0]; ex = 16'(e - bias); cl = 3'd1;
         end
      end else begin
         er = 1'b1;
      end
   endtask

   task automatic compare(input logic [2:0] f, input logic [127:0] op, input string tag);
      logic sg, iv, er; logic signed [15:0] ex; logic [114:0] mt; logic [2:0] cl;
      model(f, op, sg, ex, mt, cl, iv, er);
      checks++;
      if ({out_valid, out_sign, out_exp, out_mant, out_class, out_invalid, out_fmt_err}
          !== {1'b1, sg, ex, mt, cl, iv, er}) begin
         errors++;
         $display("FAIL %s fmt=%0d op=%h: got v=%b s=%b e=%0d m=%h c=%0d i=%b x=%b, expected v=1 s=%b e=%0d m=%h c=%0d i=%b x=%b",
                  tag, f, op, out_valid, out_sign, out_exp, out_mant, out_class, out_invalid,
                  out_fmt_err, sg, ex, mt, cl, iv, er);
      end
   endtask

   task automatic run(input logic [2:0] f, input logic [31:0] a, b, c, d, input string tag);
      logic [127:0] op;
      op = {a, b, c, d};
      @(negedge clk);
      in_fmt = f; in_w0 = a; in_w1 = b; in_w2 = c; in_w3 = d; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      // R12: unused words are zeroed for the expected value
      case (f)
         3'd0, 3'd1: op[95:0] = '0;
         3'd2:       op[63:0] = '0;
         default:    ;
      endcase
      compare(f, op, tag);
   endtask

   task automatic expect_bit(input logic act, input logic exp_v, input string tag);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, act, exp_v);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [114:0] hold_m;
      logic [15:0]  hold_e;
      repeat (3) @(negedge clk);
      // R11 reset state
      expect_bit(out_valid, 1'b0, "R11 valid");
      expect_bit(|{out_sign, out_exp, out_mant, out_class, out_invalid, out_fmt_err}, 1'b0, "R11 data");
      rst_n = 1'b1;
      @(negedge clk);
      expect_bit(out_valid, 1'b0, "R10 idle after reset");

      // R2 zeros
      run(3'd1, 32'h0000_0000, 0, 0, 0, "R2");
      run(3'd1, 32'h8000_0000, 0, 0, 0, "R2 R1");
      run(3'd2, 32'h8000_0000, 0, 0, 0, "R2");
      run(3'd3, 32'h0000_0000, 0, 0, 0, "R2");
      // R3 denormals
      run(3'd1, 32'h0000_0001, 0, 0, 0, "R3");
      run(3'd1, 32'h807F_FFFF, 0, 0, 0, "R3");
      run(3'd2, 32'h0000_0000, 32'h1, 0, 0, "R3");
      run(3'd2, 32'h000F_FFFF, 32'hFFFF_FFFF, 0, 0, "R3");
      run(3'd3, 32'h0000_0000, 0, 0, 32'h1, "R3");
      run(3'd3, 32'h8000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
      // R4 normals
      run(3'd1, 32'h0080_0000, 0, 0, 0, "R4");
      run(3'd1, 32'h7F7F_FFFF, 0, 0, 0, "R4");
      run(3'd1, 32'hBF80_0000, 0, 0, 0, "R4 R1");
      run(3'd2, 32'h3FF0_0000, 0, 0, 0, "R4");
      run(3'd2, 32'h7FEF_FFFF, 32'hFFFF_FFFF, 0, 0, "R4");
      run(3'd3, 32'hBFFF_0000, 0, 0, 0, "R4 R1");
      run(3'd3, 32'h0001_0000, 0, 0, 0, "R4");
      // R5 infinities
      run(3'd1, 32'h7F80_0000, 0, 0, 0, "R5");
      run(3'd1, 32'hFF80_0000, 0, 0, 0, "R5");
      run(3'd2, 32'hFFF0_0000, 0, 0, 0, "R5");
      run(3'd3, 32'h7FFF_0000, 0, 0, 0, "R5");
      // R6 quiet NaNs
      run(3'd1, 32'h7FC0_0000, 0, 0, 0, "R6");
      run(3'd2, 32'hFFF8_0000, 0, 0, 1, "R6");
      run(3'd3, 32'h7FFF_8000, 0, 0, 32'h5, "R6");
      // R7 signalling NaNs
      run(3'd1, 32'h7F80_0001, 0, 0, 0, "R7");
      run(3'd1, 32'h7FA0_0000, 0, 0, 0, "R7");
      run(3'd2, 32'h7FF0_0000, 32'h1, 0, 0, "R7");
      run(3'd3, 32'hFFFF_0000, 0, 0, 32'h1, "R7");
      // R8 integers
      run(3'd0, 32'h0000_0000, 0, 0, 0, "R8");
      run(3'd0, 32'h0000_0001, 0, 0, 0, "R8");
      run(3'd0, 32'hFFFF_FFFF, 0, 0, 0, "R8 R1");
      run(3'd0, 32'h8000_0000, 0, 0, 0, "R8");
      run(3'd0, 32'h7FFF_FFFF, 0, 0, 0, "R8");
      for (int k = 0; k < 32; k++) begin
         run(3'd0, 32'd1 << k, 0, 0, 0, "R8 pow");
         run(3'd0, 32'd0 - (32'd1 << k), 0, 0, 0, "R8 negpow");
      end
      // R9 illegal codes
      for (int f = 4; f < 8; f++) run(3'(f), 32'hBF80_0000, 1, 2, 3, "R9");
      // R12 unused words ignored
      run(3'd1, 32'h3F80_0001, 32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFFF, "R12");
      run(3'd0, 32'h0000_0010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R12");
      run(3'd2, 32'h4000_0000, 32'h8000_0001, 32'hFFFF_FFFF, 32'hAAAA_AAAA, "R12");

      // sweep of every single exponent with several fractions
      for (int e = 0; e < 256; e++) begin
         run(3'd1, {1'b0, 8'(e), 23'h000000}, 0, 0, 0, "R4 sweep zero-frac");
         run(3'd1, {1'b1, 8'(e), 23'h000001}, 0, 0, 0, "R3 sweep low-frac");
         run(3'd1, {1'b0, 8'(e), 23'h2AAAAA}, 0, 0, 0, "R7 sweep alt-frac");
      end
      // random operands in every legal format
      for (int n = 0; n < 300; n++) begin
         run(3'd0, rnd(), 0, 0, 0, "R8 random");
         run(3'd1, rnd(), 0, 0, 0, "R4 random");
         run(3'd2, rnd(), rnd(), 0, 0, "R4 random dbl");
         run(3'd3, rnd() & 32'h8000_0FFF, rnd(), rnd(), rnd(), "R3 random quad denorm");
         run(3'd3, rnd(), rnd(), rnd(), rnd(), "R4 random quad");
      end

      // R10 back-to-back and hold
      @(negedge clk);
      in_fmt = 3'd1; in_w0 = 32'h4049_0FDB; in_w1 = 0; in_w2 = 0; in_w3 = 0; in_valid = 1'b1;
      @(negedge clk);
      compare(3'd1, {32'h4049_0FDB, 96'd0}, "R10 first of pair");
      in_fmt = 3'd0; in_w0 = 32'hFFFF_FF00;
      @(negedge clk);
      in_valid = 1'b0;
      compare(3'd0, {32'hFFFF_FF00, 96'd0}, "R10 second of pair");
      hold_m = out_mant; hold_e = out_exp;
      in_fmt = 3'd1; in_w0 = 32'h7FC0_0000;
      repeat (2) @(negedge clk);
      expect_bit(out_valid, 1'b0, "R10 valid low when idle");
      expect_bit(out_mant == hold_m && out_exp == hold_e && out_class == 3'd1, 1'b1, "R10 hold");

      // R11 reset clears after activity
      rst_n = 1'b0;
      @(negedge clk);
      expect_bit(|{out_valid, out_sign, out_exp, out_mant, out_class}, 1'b0, "R11 reclear");
      finish_run();
   end

endmodule